// File: doc/BRIEF.md
# Two-Wire Serial Front End for a Four-Input Converter

This block is the serial-bus slave side of a small data-acquisition device that has four analog inputs and one analog output. It samples the open-drain clock and data lines with the system clock and finds START and STOP conditions. It answers to a 7-bit device address. The upper four bits of that address are a parameter and the lower three come from strap pins, so eight devices can share one bus. The converters themselves sit outside the block. The block keeps the control settings and the output-converter code, and it exchanges one request/response handshake per byte with an external conversion engine.

In a write transfer, the first byte after the address sets the control settings. Every later byte in the same transfer replaces the output code. In a read transfer, the block asks the engine for one result per byte and shifts it out MSB first. It can move to the next input channel after each byte, wrapping at the number of channels that the current input mode provides. The block never stretches the clock and does not answer general call.

Top module: `cvi_i2c_conv_if`

## Requirements
- R1: The block acknowledges an address byte only when its upper 7 bits equal {ADDR_HI, addr_pins}. On any other address it leaves SDA released until the next START.
- R2: The block acknowledges every byte it receives while addressed by pulling SDA low for the whole high phase of the ninth clock.
- R3: In a write transfer, the first byte after the address is the control byte. Its fields are bit 6 output enable, bits 5:4 input mode, bit 2 auto-advance and bits 1:0 channel. Bits 7 and 3 are ignored.
- R4: Each later byte written in the same transfer replaces dac_data. The last one wins. dac_data holds its value through read transfers and through writes that carry only a control byte.
- R5: In a read transfer, each byte begins with a one-cycle conv_req that carries the current channel on conv_chan. The byte is then sent MSB first with the value that the engine returned on conv_valid/conv_data.
- R6: With auto-advance set, every conv_req moves the channel to (channel+1) modulo N, where N is 4, 3, 3 and 2 for input modes 0, 1, 2 and 3. With auto-advance clear, the channel stays where it is.
- R7: After the master does not acknowledge a read byte, the block releases SDA and issues no further conv_req until a new START.
- R8: A repeated START always puts the block back to expecting an address byte. A write after it treats its first data byte as a control byte again.
- R9: Under reset, all register outputs are zero, SDA is released and conv_req is low.
- R10: A conv_valid that arrives in the same clock cycle as the SCL fall that loads the byte is still the value sent.
- R11: After a STOP, the block ignores bytes clocked without a START and does not acknowledge them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins | input | 3 | Strap pins for the low address bits |
| ctrl_out_en | output | 1 | Analog output enable setting |
| ctrl_in_mode | output | 2 | Input configuration mode |
| ctrl_auto_inc | output | 1 | Channel auto-advance setting |
| ctrl_chan | output | 2 | Current input channel |
| dac_data | output | 8 | Output-converter code |
| conv_req | output | 1 | One-cycle request for a conversion result |
| conv_chan | output | 2 | Channel to convert, valid with conv_req |
| conv_valid | input | 1 | Result strobe from the engine |
| conv_data | input | 8 | Result byte, valid with conv_valid |

## Verification
Two things can happen in the same clock cycle: the engine's result strobe and the SCL falling edge that loads the transmit shift register. When they coincide, the incoming value must be sent and not the older buffered copy. The bench provokes this by sweeping the engine's response delay from one cycle up to exactly the length of the request-to-load window. That window is a full SCL period after the address acknowledge and a high phase after a master acknowledge. The bench judges each case by comparing the byte it reads back with the channel and sequence number that its own engine model issued.

// File: rtl/cvi_pkg.sv
package cvi_pkg;

    localparam int BYTE_W = 8;
    localparam int CH_W   = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic            out_en;
        logic [1:0]      in_mode;
        logic            auto_inc;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BYTE,
        S_WR_ACK,
        S_RD_BYTE,
        S_RD_ACK,
        S_IGNORE
    } bus_st_t;

    // number of usable channels for each input mode
    function automatic logic [CH_W:0] chan_count(input logic [1:0] mode);
        case (mode)
            2'd0:    chan_count = 3'd4;
            2'd1:    chan_count = 3'd3;
            2'd2:    chan_count = 3'd3;
            default: chan_count = 3'd2;
        endcase
    endfunction

    function automatic logic [CH_W-1:0] chan_next(input logic [CH_W-1:0] ch,
                                                  input logic [1:0]      mode);
        logic [CH_W:0] inc;
        inc = {1'b0, ch} + 1'b1;
        chan_next = (inc >= chan_count(mode)) ? '0 : inc[CH_W-1:0];
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.out_en   = b[6];
        c.in_mode  = b[5:4];
        c.auto_inc = b[2];
        c.chan     = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/cvi_bus_sync.sv
module cvi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] chain [STAGES];
    logic       scl_p, sda_p, scl_s;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 2'b11;
                    else     chain[g] <= {scl_in, sda_in};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 2'b11;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = chain[STAGES-1][1];
    assign sda_s = chain[STAGES-1][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/cvi_link_fsm.sv
module cvi_link_fsm
    import cvi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [6:0]        dev_addr,
    input  logic              conv_valid,
    input  logic [BYTE_W-1:0] conv_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              wr_is_ctrl,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_req
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_st_t           st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg, txreg, rdbuf, fresh;
    logic              rw, seen_ctrl, m_acked;

    // result arriving in the load cycle takes precedence over the buffer
    assign fresh = conv_valid ? conv_data : rdbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            rdbuf      <= '0;
            sda_oe     <= 1'b0;
            rw         <= 1'b0;
            seen_ctrl  <= 1'b0;
            m_acked    <= 1'b0;
            rd_req     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_is_ctrl <= 1'b0;
            wr_byte    <= '0;
        end else begin
            rd_req <= 1'b0;
            wr_stb <= 1'b0;
            if (conv_valid) rdbuf <= conv_data;
            if (start_ev) begin
                st        <= S_ADDR;
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                seen_ctrl <= 1'b0;
                m_acked   <= 1'b0;
            end else if (stop_ev) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    S_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            if (shreg[7:1] == dev_addr) begin
                                st     <= S_ADDR_ACK;
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                rd_req <= shreg[0];
                            end else begin
                                st <= S_IGNORE;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                txreg  <= fresh;
                                sda_oe <= ~fresh[BYTE_W-1];
                                bitcnt <= CNT_W'(1);
                                st     <= S_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                st     <= S_WR_BYTE;
                            end
                        end
                    end
                    S_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            sda_oe     <= 1'b1;
                            st         <= S_WR_ACK;
                            wr_stb     <= 1'b1;
                            wr_is_ctrl <= ~seen_ctrl;
                            wr_byte    <= shreg;
                            seen_ctrl  <= 1'b1;
                        end
                    end
                    S_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            st     <= S_WR_BYTE;
                        end
                    end
                    S_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                st     <= S_RD_ACK;
                            end else begin
                                sda_oe <= ~txreg[BYTE_W-2];
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            if (!sda_s) begin
                                rd_req  <= 1'b1;
                                m_acked <= 1'b1;
                            end else begin
                                st <= S_IGNORE;
                            end
                        end else if (scl_fall && m_acked) begin
                            txreg   <= fresh;
                            sda_oe  <= ~fresh[BYTE_W-1];
                            bitcnt  <= CNT_W'(1);
                            m_acked <= 1'b0;
                            st      <= S_RD_BYTE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_ack_ninth_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_WR_ACK) |-> sda_oe);

    p_quiet_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_IGNORE) |-> !sda_oe);

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_req_in_read_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rw);

    p_restart_addr_r8: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (st == S_ADDR && !sda_oe));

endmodule

// File: rtl/cvi_regs.sv
module cvi_regs
    import cvi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              wr_is_ctrl,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              adv,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] dac_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dac_q  <= '0;
        end else begin
            if (wr_stb) begin
                if (wr_is_ctrl) ctrl_q <= ctrl_decode(wr_byte);
                else            dac_q  <= wr_byte;
            end else if (adv && ctrl_q.auto_inc) begin
                ctrl_q.chan <= chan_next(ctrl_q.chan, ctrl_q.in_mode);
            end
        end
    end

    p_dac_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && !wr_is_ctrl) |=> $stable(dac_q));

    p_chan_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !(adv && ctrl_q.auto_inc)) |=> $stable(ctrl_q));

endmodule

// File: rtl/cvi_i2c_conv_if.sv
module cvi_i2c_conv_if
    import cvi_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b1001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        addr_pins,
    output logic              ctrl_out_en,
    output logic [1:0]        ctrl_in_mode,
    output logic              ctrl_auto_inc,
    output logic [CH_W-1:0]   ctrl_chan,
    output logic [BYTE_W-1:0] dac_data,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_valid,
    input  logic [BYTE_W-1:0] conv_data
);
    logic              scl_rise, scl_fall, sda_s, start_ev, stop_ev;
    logic              wr_stb, wr_is_ctrl, rd_req;
    logic [BYTE_W-1:0] wr_byte;
    ctrl_t             ctrl_q;

    cvi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    cvi_link_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .dev_addr   ({ADDR_HI, addr_pins}),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .sda_oe     (sda_oe),
        .wr_stb     (wr_stb),
        .wr_is_ctrl (wr_is_ctrl),
        .wr_byte    (wr_byte),
        .rd_req     (rd_req)
    );

    cvi_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_is_ctrl (wr_is_ctrl),
        .wr_byte    (wr_byte),
        .adv        (rd_req),
        .ctrl_q     (ctrl_q),
        .dac_q      (dac_data)
    );

    assign ctrl_out_en   = ctrl_q.out_en;
    assign ctrl_in_mode  = ctrl_q.in_mode;
    assign ctrl_auto_inc = ctrl_q.auto_inc;
    assign ctrl_chan     = ctrl_q.chan;
    assign conv_req      = rd_req;
    assign conv_chan     = ctrl_q.chan;

    p_sda_free_idle_r11: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

endmodule

// File: tb/sim_cvi_i2c_conv_if.sv
module sim_cvi_i2c_conv_if;

    localparam logic [6:0] DEV = 7'b1001101;
    localparam int NVEC = 6;
    // {control byte, engine delay, bytes to read}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'd1, 8'd3},
        {8'h06, 8'd3, 8'd4},
        {8'h15, 8'd8, 8'd4},
        {8'h26, 8'd5, 8'd3},
        {8'h35, 8'd2, 8'd3},
        {8'hC9, 8'd8, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] pins = 3'b101;
    logic sda_oe, out_en, auto_inc, conv_req, conv_valid;
    logic [1:0] in_mode, chan, conv_chan;
    logic [7:0] dac, conv_data;
    wire sda_line = ~(m_low | sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    int eng_delay = 1;
    int eng_reqs = 0;
    logic [5:0] seq = '0;
    logic [5:0] exp_seq = '0;

    always #4 clk = ~clk;

    cvi_i2c_conv_if u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_pins(pins), .ctrl_out_en(out_en), .ctrl_in_mode(in_mode),
        .ctrl_auto_inc(auto_inc), .ctrl_chan(chan), .dac_data(dac),
        .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_valid(conv_valid), .conv_data(conv_data)
    );

    // conversion engine model
    initial begin
        conv_valid = 1'b0;
        conv_data  = '0;
        forever begin
            @(negedge clk);
            if (conv_req === 1'b1) begin
                logic [1:0] ch;
                ch = conv_chan;
                eng_reqs++;
                repeat (eng_delay - 1) @(negedge clk);
                conv_data  = {ch, seq};
                conv_valid = 1'b1;
                @(negedge clk);
                conv_valid = 1'b0;
                seq = seq + 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] m_next(input logic [1:0] c, input logic [1:0] mode);
        int n;
        n = (mode == 0) ? 4 : (mode == 3) ? 2 : 3;
        return (int'(c) + 1 >= n) ? 2'd0 : c + 2'd1;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b1; wait_n(4);
        scl = 1'b0;   wait_n(4);
    endtask

    task automatic bus_restart();
        wait_n(4); m_low = 1'b0;
        wait_n(4); scl = 1'b1;
        wait_n(4); m_low = 1'b1;
        wait_n(4); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(4); m_low = 1'b1;
        wait_n(4); scl = 1'b1;
        wait_n(4); m_low = 1'b0;
        wait_n(8);
    endtask

    task automatic clock_bit(input logic drv_low, output logic smp, output logic steady);
        logic s1, s2;
        wait_n(4); m_low = drv_low;
        wait_n(4); scl = 1'b1;
        wait_n(1); s1 = sda_line;
        wait_n(3); smp = sda_line;
        wait_n(3); s2 = sda_line;
        wait_n(1); scl = 1'b0;
        steady = (s1 == smp) && (s2 == smp);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic s, st;
        for (int i = 7; i >= 0; i--) clock_bit(~b[i], s, st);
        clock_bit(1'b0, s, st);
        acked = (s == 1'b0) && st;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] b);
        logic s, st;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b0, s, st);
            b = {b[6:0], s};
        end
        clock_bit(m_ack, s, st);
        m_low = 1'b0;
    endtask

    initial begin
        logic ack;
        logic [7:0] rb, cb;
        logic [1:0] ech;
        int nb;

        wait_n(5);
        chk("R9 sda released in reset", sda_oe, 0);
        chk("R9 control zero in reset", {out_en, in_mode, auto_inc, chan}, 0);
        chk("R9 dac zero in reset", dac, 0);
        chk("R9 no request in reset", conv_req, 0);
        rst = 1'b0;
        wait_n(5);

        // table-driven write/read transfers
        for (int i = 0; i < NVEC; i++) begin
            cb        = VEC[i][23:16];
            eng_delay = int'(VEC[i][15:8]);
            nb        = int'(VEC[i][7:0]);
            bus_start();
            write_byte({DEV, 1'b0}, ack); chk("R1 address ack (write)", ack, 1);
            write_byte(cb, ack);          chk("R2 control byte ack", ack, 1);
            write_byte(8'h5A ^ 8'(i), ack); chk("R2 data byte ack", ack, 1);
            chk("R3 control fields", {out_en, in_mode, auto_inc, chan},
                {cb[6], cb[5:4], cb[2], cb[1:0]});
            chk("R4 dac written", dac, 8'h5A ^ 8'(i));
            bus_restart();
            write_byte({DEV, 1'b1}, ack); chk("R8 R1 address ack after restart", ack, 1);
            ech = cb[1:0];
            for (int j = 0; j < nb; j++) begin
                read_byte(j != nb - 1, rb);
                chk("R5 R6 R10 read byte", rb, {ech, exp_seq});
                exp_seq = exp_seq + 1'b1;
                if (cb[2]) ech = m_next(ech, cb[5:4]);
            end
            bus_stop();
            chk("R6 channel after read", chan, ech);
            chk("R4 dac held over read", dac, 8'h5A ^ 8'(i));
        end

        // R10: result lands in the very cycle the first byte is loaded
        eng_delay = 16;
        bus_start();
        write_byte({DEV, 1'b1}, ack); chk("R1 address ack (read)", ack, 1);
        read_byte(1'b0, rb);
        chk("R10 same-cycle result used", rb, {2'd1, exp_seq});
        exp_seq = exp_seq + 1'b1;
        bus_stop();
        eng_delay = 2;

        // R4: several data bytes, last one wins; control-only write keeps dac
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h02, ack);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        write_byte(8'h33, ack); chk("R2 third data byte ack", ack, 1);
        bus_stop();
        chk("R4 last data byte wins", dac, 8'h33);
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h41, ack);
        bus_stop();
        chk("R3 control-only write", {out_en, in_mode, auto_inc, chan}, 6'b1_00_0_01);
        chk("R4 dac kept on control-only write", dac, 8'h33);

        // R1: foreign address ignored until next START
        bus_start();
        write_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R1 foreign address not acked", ack, 0);
        write_byte(8'h07, ack);               chk("R1 byte after foreign address not acked", ack, 0);
        chk("R1 control unchanged by foreign transfer", chan, 2'd1);
        bus_restart();
        write_byte({DEV, 1'b0}, ack); chk("R1 own address after restart", ack, 1);
        write_byte(8'h03, ack);       chk("R8 control byte after restart", ack, 1);
        bus_stop();
        chk("R8 first byte taken as control", chan, 2'd3);
        chk("R8 dac untouched", dac, 8'h33);

        // R7: master NACK ends transmission
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        read_byte(1'b0, rb);
        chk("R5 read channel 3", rb, {2'd3, exp_seq});
        exp_seq = exp_seq + 1'b1;
        nb = eng_reqs;
        read_byte(1'b0, rb);
        chk("R7 sda released after nack", rb, 8'hFF);
        chk("R7 no request after nack", eng_reqs, nb);
        bus_stop();

        // R11: after STOP no response without START
        write_byte({DEV, 1'b0}, ack);
        chk("R11 no ack without start", ack, 0);
        bus_stop();

        // R9: reset mid-transfer
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        rst = 1'b1;
        wait_n(3);
        chk("R9 control cleared by reset", {out_en, in_mode, auto_inc, chan}, 0);
        chk("R9 dac cleared by reset", dac, 0);
        chk("R9 sda released by reset", sda_oe, 0);
        rst = 1'b0;
        bus_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule